// File: doc/BRIEF.md
# Status Condition/Event/Enable Register Group

This block keeps one 16-bit status group of the kind an instrument's remote-control status system keeps twice: once for operating activity and once for doubtful measurement conditions. A condition register mirrors the live status inputs from one cycle to the next. An event register captures each 0-to-1 change of a condition bit and keeps it until software takes it away. An enable mask picks which captured events drive one summary output, and that output is wired into a bit of the device status byte.

Software reaches the group through a small request port. A request carries an operation code and, for writes, a data word. The block answers reads one cycle later with a response strobe. The operations are: read the condition register, read the event register and clear it, write the enable mask, read the enable mask, preset, and clear events without reading them. A parameter mask gives the bit positions that exist. Every other position is held at 0 in all three registers. The default mask 16'h0301 gives the operating group: calibrating at bit 0, self-test at bit 8, and power-up self-test at bit 9. The mask 16'h0610 gives the questionable group: reference-junction temperature at bit 4, and current warnings at bits 9 and 10.

Top module: `stat_reg_group`

## Requirements
- R1: One clock edge after `status_in` changes, the condition register holds `status_in & IMPL_MASK`. It is not sticky, so a bit that returns to 0 reads 0 again.
- R2: An event bit is set at the clock edge where its condition bit goes from 0 to 1. A change from 1 to 0 sets nothing.
- R3: An event bit stays set across any number of cycles until an event read or an event clear takes place.
- R4: An event read (op 1) returns the event register as it was before the request edge, then clears it. A rising condition bit in the same cycle as the read stays set after the read.
- R5: An event clear (op 5) zeroes the event register and gives no response. A rising condition bit in the same cycle stays set.
- R6: `summary` is 1 exactly when some bit is set both in the event register and in the enable mask. It follows the registers with no added delay.
- R7: An enable write (op 2) loads `req_wdata & IMPL_MASK`. An enable read (op 3) returns the mask.
- R8: Preset (op 4) zeroes the enable mask and leaves the condition and event registers unchanged.
- R9: Bit positions that are clear in `IMPL_MASK` read 0 in the condition, event and enable registers, whatever the inputs or the written data.
- R10: After reset, all three registers are 0, `summary` is 0 and `rsp_valid` is 0.
- R11: For a request accepted at one edge, reads (op 0 condition, op 1 event, op 3 enable) raise `rsp_valid` for exactly the next cycle with `rsp_data`. Ops 2, 4 and 5 and the unused codes 6 and 7 raise no response. Codes 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| status_in | input | WIDTH | Live internal status levels |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0..5 used) |
| req_wdata | input | WIDTH | Data for enable write |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | WIDTH | Read response data |
| summary | output | 1 | OR of enabled event bits, to the status byte |

## Verification
Two functions can land on the same edge: a condition bit rising, and an event read or event clear that wipes the register. The bench provokes this by raising a status input in the same cycle that it issues the read or clear. It then judges two things. The read response must hold only the earlier events. A read that follows must show the new bit alone. A second overlap puts a preset next to pending events, and the bench checks through later reads that the preset clears only the enable mask.

// File: rtl/stat_grp_pkg.sv
package stat_grp_pkg;

    typedef enum logic [2:0] {
        OP_COND_RD = 3'd0,
        OP_EVT_RD  = 3'd1,
        OP_ENA_WR  = 3'd2,
        OP_ENA_RD  = 3'd3,
        OP_PRESET  = 3'd4,
        OP_CLEAR   = 3'd5
    } grp_op_e;

    localparam int OP_W = 3;

endpackage

// File: rtl/sgrp_cond_stage.sv
module sgrp_cond_stage #(
    parameter int                 WIDTH     = 16,
    parameter logic [WIDTH-1:0]   IMPL_MASK = 16'h0301
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] status_in,
    output logic [WIDTH-1:0] cond_q,
    output logic [WIDTH-1:0] rise
);

    typedef struct packed {
        logic [WIDTH-1:0] cond;
    } cond_st_t;

    cond_st_t         st_d, st_q;
    logic [WIDTH-1:0] live;

    // Only implemented positions see the input; the rest are constant 0.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        if (IMPL_MASK[gi]) begin : g_on
            assign live[gi] = status_in[gi];
        end else begin : g_off
            assign live[gi] = 1'b0;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.cond = live;
        rise      = live & ~st_q.cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cond_q = st_q.cond;

endmodule

// File: rtl/sgrp_event_store.sv
module sgrp_event_store #(
    parameter int                 WIDTH     = 16,
    parameter logic [WIDTH-1:0]   IMPL_MASK = 16'h0301
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rise,
    input  logic             wipe,
    output logic [WIDTH-1:0] evt_q
);

    typedef struct packed {
        logic [WIDTH-1:0] evt;
    } evt_st_t;

    evt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // A wipe removes old events; a rise on the same edge still lands.
        if (wipe) st_d.evt = '0;
        st_d.evt = (st_d.evt | rise) & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_q = st_q.evt;

endmodule

// File: rtl/sgrp_enable_sum.sv
module sgrp_enable_sum #(
    parameter int                 WIDTH     = 16,
    parameter logic [WIDTH-1:0]   IMPL_MASK = 16'h0301
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             preset,
    input  logic [WIDTH-1:0] evt,
    output logic [WIDTH-1:0] ena_q,
    output logic             summary
);

    typedef struct packed {
        logic [WIDTH-1:0] ena;
    } ena_st_t;

    ena_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (preset)     st_d.ena = '0;
        else if (wr_en) st_d.ena = wr_data & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ena_q   = st_q.ena;
    assign summary = |(evt & st_q.ena);

endmodule

// File: rtl/stat_reg_group.sv
module stat_reg_group
    import stat_grp_pkg::*;
#(
    parameter int                 WIDTH     = 16,
    parameter logic [WIDTH-1:0]   IMPL_MASK = 16'h0301
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] status_in,
    input  logic             req_valid,
    input  logic [OP_W-1:0]  req_op,
    input  logic [WIDTH-1:0] req_wdata,
    output logic             rsp_valid,
    output logic [WIDTH-1:0] rsp_data,
    output logic             summary
);

    typedef struct packed {
        logic             vld;
        logic [WIDTH-1:0] data;
    } rsp_st_t;

    rsp_st_t          rsp_d, rsp_q;
    grp_op_e          op;
    logic [WIDTH-1:0] cond_q, evt_q, ena_q, rise;
    logic             do_cond_rd, do_evt_rd, do_ena_wr, do_ena_rd;
    logic             do_preset, do_clear;

    assign op = grp_op_e'(req_op);

    always_comb begin
        do_cond_rd = req_valid && (op == OP_COND_RD);
        do_evt_rd  = req_valid && (op == OP_EVT_RD);
        do_ena_wr  = req_valid && (op == OP_ENA_WR);
        do_ena_rd  = req_valid && (op == OP_ENA_RD);
        do_preset  = req_valid && (op == OP_PRESET);
        do_clear   = req_valid && (op == OP_CLEAR);
    end

    sgrp_cond_stage #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_in (status_in),
        .cond_q    (cond_q),
        .rise      (rise)
    );

    sgrp_event_store #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (rise),
        .wipe  (do_evt_rd || do_clear),
        .evt_q (evt_q)
    );

    sgrp_enable_sum #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_ena (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (do_ena_wr),
        .wr_data (req_wdata),
        .preset  (do_preset),
        .evt     (evt_q),
        .ena_q   (ena_q),
        .summary (summary)
    );

    always_comb begin
        rsp_d      = '0;
        rsp_d.vld  = do_cond_rd || do_evt_rd || do_ena_rd;
        if (do_cond_rd)     rsp_d.data = cond_q;
        else if (do_evt_rd) rsp_d.data = evt_q;
        else if (do_ena_rd) rsp_d.data = ena_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_data  = rsp_q.data;

endmodule

// File: rtl/sgrp_checker.sv
module sgrp_checker #(
    parameter int                 WIDTH     = 16,
    parameter logic [WIDTH-1:0]   IMPL_MASK = 16'h0301
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] status_in,
    input logic             req_valid,
    input logic [2:0]       req_op,
    input logic             rsp_valid,
    input logic [WIDTH-1:0] rsp_data,
    input logic             summary,
    input logic [WIDTH-1:0] cond_q,
    input logic [WIDTH-1:0] evt_q,
    input logic [WIDTH-1:0] ena_q
);

    logic wiping;
    assign wiping = req_valid && (req_op == 3'd1 || req_op == 3'd5);

    // R1
    cond_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cond_q == ($past(status_in) & IMPL_MASK));

    // R3
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wiping |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

    // R4
    evt_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd1) |=> (rsp_valid && rsp_data == $past(evt_q)));

    // R8
    preset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd4) |=> (ena_q == '0 && !summary));

    // R9
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cond_q | evt_q | ena_q) & ~IMPL_MASK) == '0);

    // R11
    no_rsp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_op == 3'd2 || req_op == 3'd4 || req_op == 3'd5
         || req_op == 3'd6 || req_op == 3'd7) |=> !rsp_valid);

endmodule

bind stat_reg_group sgrp_checker #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_in (status_in),
    .req_valid (req_valid),
    .req_op    (req_op),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .summary   (summary),
    .cond_q    (cond_q),
    .evt_q     (evt_q),
    .ena_q     (ena_q)
);

// File: tb/tb_stat_reg_group.sv
module tb_stat_reg_group;

    localparam logic [15:0] M = 16'h0301;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] status_in = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        summary;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] exp_data[$];
    string       exp_tag[$];

    // bench model state
    logic [15:0] cond_m = '0, evt_m = '0, ena_m = '0;

    always #10 clk = ~clk;

    stat_reg_group #(.WIDTH(16), .IMPL_MASK(M)) dut (
        .clk(clk), .rst_n(rst_n), .status_in(status_in),
        .req_valid(req_valid), .req_op(req_op), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .summary(summary)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle; the model predicts the response and next state.
    task automatic step(input logic [15:0] s, input bit v, input logic [2:0] op,
                        input logic [15:0] wd, input string tag);
        logic [15:0] sm, rs;
        @(negedge clk);
        check("R6 summary", {15'd0, summary}, {15'd0, |(evt_m & ena_m)});
        status_in = s; req_valid = v; req_op = op; req_wdata = wd;
        sm = s & M;
        rs = sm & ~cond_m;
        if (v) begin
            case (op)
                3'd0: begin exp_data.push_back(cond_m); exp_tag.push_back(tag); end
                3'd1: begin exp_data.push_back(evt_m);  exp_tag.push_back(tag); end
                3'd3: begin exp_data.push_back(ena_m);  exp_tag.push_back(tag); end
                default: ;
            endcase
        end
        evt_m  = ((v && (op == 3'd1 || op == 3'd5)) ? 16'h0 : evt_m) | rs;
        if (v && op == 3'd2) ena_m = wd & M;
        if (v && op == 3'd4) ena_m = '0;
        cond_m = sm;
    endtask

    task automatic idle(input logic [15:0] s);
        step(s, 1'b0, 3'd0, 16'h0, "idle");
    endtask

    // monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_data.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R11 unexpected response: actual %h expected none", rsp_data);
            end else begin
                check(exp_tag.pop_front(), rsp_data, exp_data.pop_front());
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state at the ports
        check("R10 summary at reset", {15'd0, summary}, 16'h0);
        check("R10 rsp_valid at reset", {15'd0, rsp_valid}, 16'h0);
        rst_n = 1'b1;
        step(16'h0000, 1, 3'd0, 0, "R10 cond after reset");
        step(16'h0000, 1, 3'd1, 0, "R10 evt after reset");
        step(16'h0000, 1, 3'd3, 0, "R10 ena after reset");
        // R1 R9 R2: all inputs high, masked positions stay 0
        idle(16'hFFFF);
        step(16'hFFFF, 1, 3'd0, 0, "R1 R9 cond masked");
        step(16'hFFFF, 1, 3'd1, 0, "R2 R4 evt read");
        step(16'hFFFF, 1, 3'd1, 0, "R4 evt cleared by read");
        // R2 falling edge does not set, R1 not sticky
        idle(16'h0000);
        step(16'h0000, 1, 3'd1, 0, "R2 fall sets nothing");
        step(16'h0000, 1, 3'd0, 0, "R1 cond not sticky");
        // R3 sticky over pulse
        idle(16'h0001);
        idle(16'h0000);
        idle(16'h0000);
        idle(16'h0000);
        step(16'h0000, 1, 3'd1, 0, "R3 sticky event");
        // R4 rise in same cycle as read is kept
        idle(16'h0001);
        step(16'h0101, 1, 3'd1, 0, "R4 read with concurrent rise");
        step(16'h0101, 1, 3'd1, 0, "R4 concurrent rise kept");
        // R5 clear with concurrent rise
        idle(16'h0000);
        idle(16'h0100);
        step(16'h0300, 1, 3'd5, 0, "R5 clear");
        step(16'h0300, 1, 3'd1, 0, "R5 concurrent rise kept");
        // R7 R9 enable write and read
        step(16'h0000, 1, 3'd2, 16'hFFFF, "R7 write");
        step(16'h0000, 1, 3'd3, 0, "R7 R9 ena readback");
        // R6 summary with selective enable
        step(16'h0000, 1, 3'd2, 16'h0200, "R6 ena bit9");
        idle(16'h0100);
        idle(16'h0100);
        step(16'h0100, 1, 3'd0, 0, "R6 cond during unenabled event");
        idle(16'h0300);
        idle(16'h0300);
        // R8 preset keeps cond and events
        step(16'h0300, 1, 3'd4, 0, "R8 preset");
        step(16'h0300, 1, 3'd3, 0, "R8 ena zero after preset");
        step(16'h0300, 1, 3'd0, 0, "R8 cond kept");
        step(16'h0300, 1, 3'd1, 0, "R8 evt kept");
        // R11 unused codes change nothing and answer nothing
        idle(16'h0000);
        idle(16'h0001);
        step(16'h0001, 1, 3'd6, 16'hFFFF, "R11 op6");
        step(16'h0001, 1, 3'd7, 16'hFFFF, "R11 op7");
        step(16'h0001, 1, 3'd3, 0, "R11 ena unchanged");
        step(16'h0001, 1, 3'd1, 0, "R11 evt unchanged");
        idle(16'h0000);
        idle(16'h0000);
        @(negedge clk);
        check("R11 all responses seen", 16'(exp_data.size()), 16'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule